// File: doc/BRIEF.md
# Checkerboard and Ramp Test Image Generator

This block sits after a video timing generator and replaces the active picture with a synthetic test image. It watches three strobes from the timing side: a data-enable that is high for each active pixel, a one-cycle pulse at the start of every line, and a one-cycle pulse at the start of every frame. A two-bit selector picks among three behaviours. In the off state the incoming video word passes through untouched. In checkerboard state the active area alternates between two programmable colours, with a separate run length for each colour and a programmable number of lines after which the starting colour swaps. In ramp state every channel climbs from zero by a programmable step on each pixel of a line.

Every output is registered once, so the pixel word and its valid flag both trail the data-enable by exactly one clock. The selector is sampled only on the frame-start pulse, which means software may write it at any time without tearing the picture. Colour words keep the same byte layout on input and output, so the block needs no knowledge of the colour order beyond passing words through.

Top module: `testpat_gen`

## Requirements
- R1: The selector `mode_i` is captured only in a cycle where `frame_start_i` is high; the captured value governs pixels from the following cycle on, and changes to `mode_i` at any other time have no effect on the output.
- R2: When the captured selector is 0 (off) or 3 (reserved, treated as off), `pix_o` equals `pass_pix_i` from the previous cycle, whatever the state of `de_i`.
- R3: In every mode `valid_o` equals `de_i` delayed by one clock.
- R4: When the captured selector is 1 (checkerboard) or 2 (ramp) and `de_i` was low in the previous cycle, `pix_o` is all zeros.
- R5: In checkerboard mode (selector 1) each line starts, at the rising edge of `de_i`, with colour A if the row phase is even and colour B if it is odd; colour A then lasts `run_a_i` pixels and colour B lasts `run_b_i` pixels, alternately, to the end of the line. A run value of 0 means 256 pixels.
- R6: The row phase is even after a frame-start pulse and inverts each time the number of line-start pulses counted since that frame start reaches a multiple of `alt_lines_i`; a value of 0 means 256 lines. A frame-start pulse in the same cycle as a line-start pulse wins.
- R7: In ramp mode (selector 2) the pixel at position x of a line (x = 0 at the rising edge of `de_i`) has each of its three 8-bit channels equal to x times `ramp_step_i`, modulo 256.
- R8: Colour words are carried unchanged from `color_a_i`/`color_b_i` to `pix_o`: bits 23:16 hold blue, bits 15:8 green and bits 7:0 red on both sides.
- R9: While `rst_n` is low at a clock edge, `pix_o` and `valid_o` become zero and the captured selector becomes off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| de_i | input | 1 | Active-pixel enable from the timing generator |
| line_start_i | input | 1 | One-cycle pulse at the start of each line |
| frame_start_i | input | 1 | One-cycle pulse at the start of each frame |
| mode_i | input | 2 | Pattern selector: 0 off, 1 checkerboard, 2 ramp, 3 reserved |
| color_a_i | input | 24 | Checkerboard colour A, {blue, green, red} |
| color_b_i | input | 24 | Checkerboard colour B, {blue, green, red} |
| run_a_i | input | 8 | Pixels per colour-A run (0 means 256) |
| run_b_i | input | 8 | Pixels per colour-B run (0 means 256) |
| alt_lines_i | input | 8 | Lines between row-phase inversions (0 means 256) |
| ramp_step_i | input | 8 | Per-pixel increment in ramp mode |
| pass_pix_i | input | 24 | Video word forwarded when the generator is off |
| pix_o | output | 24 | Registered output pixel |
| valid_o | output | 1 | Registered data-enable matching `pix_o` |

## Verification
A stuck or miscounted run counter shows up as a wrong colour at the first pixel past a run boundary, one clock after that pixel's data-enable, so short random run lengths expose it within a few pixels of every line. A wrong row-phase counter only appears at the first pixel of a line whose phase should have flipped, so the bench drives several lines per frame with small alternation counts. A selector latch that follows the input early is caught on the first pixel after a mid-frame selector change, while a ramp accumulator that fails to restart shows as a non-zero first pixel on the next line.

// File: rtl/testpat_pkg.sv
// Package testpat_pkg
// Shared selector encoding and sizes for the test image generator.
// Assumes: colour words are three equal-width channels.
package testpat_pkg;

    localparam int unsigned TP_CH_W  = 8;
    localparam int unsigned TP_NUM_CH = 3;
    localparam int unsigned TP_PIX_W = TP_CH_W * TP_NUM_CH;

    typedef enum logic [1:0] {
        TP_OFF     = 2'd0,
        TP_CHECKER = 2'd1,
        TP_RAMP    = 2'd2,
        TP_RSVD    = 2'd3
    } tp_mode_e;

endpackage

// File: rtl/tp_row_phase.sv
// Module tp_row_phase
// Counts line-start pulses since the last frame start and flips a phase
// bit each time the count reaches the programmed alternation period.
// Assumes: a period of 0 stands for 2**CNT_W lines (counter wraps).
module tp_row_phase #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic             line_start_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             phase_o
);

    logic [CNT_W-1:0] line_cnt_q;
    logic [CNT_W-1:0] line_cnt_inc;
    logic             period_hit;

    // Next count value and end-of-period detect.
    always_comb begin
        line_cnt_inc = line_cnt_q + 1'b1;
        period_hit   = (line_cnt_inc == period_i);
    end

    // Line counter and phase register; frame start takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt_q <= '0;
            phase_o    <= 1'b0;
        end else if (frame_start_i) begin
            line_cnt_q <= '0;
            phase_o    <= 1'b0;
        end else if (line_start_i) begin
            if (period_hit) begin
                line_cnt_q <= '0;
                phase_o    <= ~phase_o;
            end else begin
                line_cnt_q <= line_cnt_inc;
            end
        end
    end

endmodule

// File: rtl/tp_checker_col.sv
// Module tp_checker_col
// Chooses colour A or B for the current pixel. At each data-enable rise
// the choice restarts from the row phase; each colour then runs for its
// own programmed length before the other takes over.
// Assumes: a run length of 0 stands for 2**CNT_W pixels.
module tp_checker_col #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de_i,
    input  logic             de_rise_i,
    input  logic             row_phase_i,
    input  logic [CNT_W-1:0] run_a_i,
    input  logic [CNT_W-1:0] run_b_i,
    output logic             use_b_o
);

    logic             sel_b_q;
    logic [CNT_W-1:0] run_cnt_q;
    logic [CNT_W-1:0] cur_cnt;
    logic [CNT_W-1:0] cur_cnt_inc;
    logic [CNT_W-1:0] cur_len;
    logic             run_done;

    // Current colour and position within its run, restarted at line start.
    always_comb begin
        use_b_o     = de_rise_i ? row_phase_i : sel_b_q;
        cur_cnt     = de_rise_i ? '0 : run_cnt_q;
        cur_len     = use_b_o ? run_b_i : run_a_i;
        cur_cnt_inc = cur_cnt + 1'b1;
        run_done    = (cur_cnt_inc == cur_len);
    end

    // Advance the run state on each active pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_b_q   <= 1'b0;
            run_cnt_q <= '0;
        end else if (de_i) begin
            if (run_done) begin
                sel_b_q   <= ~use_b_o;
                run_cnt_q <= '0;
            end else begin
                sel_b_q   <= use_b_o;
                run_cnt_q <= cur_cnt_inc;
            end
        end
    end

endmodule

// File: rtl/tp_ramp.sv
// Module tp_ramp
// Produces a per-line ramp: every channel is zero on the first active
// pixel and grows by the step on each following pixel, wrapping.
// Assumes: all channels share one step; one accumulator per channel.
module tp_ramp #(
    parameter int unsigned CH_W   = 8,
    parameter int unsigned NUM_CH = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   de_i,
    input  logic                   de_rise_i,
    input  logic [CH_W-1:0]        step_i,
    output logic [NUM_CH*CH_W-1:0] level_o
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic [CH_W-1:0] acc_q;
        logic [CH_W-1:0] cur;

        // Channel value for the current pixel.
        always_comb begin
            cur = de_rise_i ? '0 : acc_q;
        end

        // Accumulate the step on each active pixel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (de_i) begin
                acc_q <= cur + step_i;
            end
        end

        assign level_o[ch*CH_W +: CH_W] = cur;
    end

endmodule

// File: rtl/testpat_gen.sv
// Module testpat_gen
// Test image generator top. Latches the selector at frame start, builds
// the checkerboard and ramp candidates, and registers the chosen pixel
// together with a one-cycle-delayed data-enable.
// Assumes: strobes come from a timing generator in the clk domain and
// the colour, run and step settings are steady during a frame.
module testpat_gen
    import testpat_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                de_i,
    input  logic                line_start_i,
    input  logic                frame_start_i,
    input  logic [1:0]          mode_i,
    input  logic [TP_PIX_W-1:0] color_a_i,
    input  logic [TP_PIX_W-1:0] color_b_i,
    input  logic [CNT_W-1:0]    run_a_i,
    input  logic [CNT_W-1:0]    run_b_i,
    input  logic [CNT_W-1:0]    alt_lines_i,
    input  logic [TP_CH_W-1:0]  ramp_step_i,
    input  logic [TP_PIX_W-1:0] pass_pix_i,
    output logic [TP_PIX_W-1:0] pix_o,
    output logic                valid_o
);

    tp_mode_e            mode_q;
    logic                de_rise;
    logic                row_phase;
    logic                use_b;
    logic [TP_PIX_W-1:0] ramp_pix;
    logic [TP_PIX_W-1:0] pix_nxt;

    // Start of an active run: valid_o holds last cycle's data-enable.
    always_comb begin
        de_rise = de_i & ~valid_o;
    end

    // Capture the selector only on frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= TP_OFF;
        end else if (frame_start_i) begin
            mode_q <= tp_mode_e'(mode_i);
        end
    end

    tp_row_phase #(
        .CNT_W (CNT_W)
    ) u_row (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .line_start_i  (line_start_i),
        .period_i      (alt_lines_i),
        .phase_o       (row_phase)
    );

    tp_checker_col #(
        .CNT_W (CNT_W)
    ) u_col (
        .clk         (clk),
        .rst_n       (rst_n),
        .de_i        (de_i),
        .de_rise_i   (de_rise),
        .row_phase_i (row_phase),
        .run_a_i     (run_a_i),
        .run_b_i     (run_b_i),
        .use_b_o     (use_b)
    );

    tp_ramp #(
        .CH_W   (TP_CH_W),
        .NUM_CH (TP_NUM_CH)
    ) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .de_i      (de_i),
        .de_rise_i (de_rise),
        .step_i    (ramp_step_i),
        .level_o   (ramp_pix)
    );

    // Pick the pixel source for the active selector.
    always_comb begin
        unique case (mode_q)
            TP_CHECKER: pix_nxt = de_i ? (use_b ? color_b_i : color_a_i) : '0;
            TP_RAMP:    pix_nxt = de_i ? ramp_pix : '0;
            default:    pix_nxt = pass_pix_i;
        endcase
    end

    // Output register stage for pixel and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            pix_o   <= pix_nxt;
            valid_o <= de_i;
        end
    end

endmodule

// File: rtl/testpat_gen_checks.sv
// Module testpat_gen_checks
// Property checker bound to testpat_gen. Observes ports plus the latched
// selector and row phase, which come from separate logic.
module testpat_gen_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        de_i,
    input logic        frame_start_i,
    input logic [23:0] color_a_i,
    input logic [23:0] color_b_i,
    input logic [23:0] pass_pix_i,
    input logic [23:0] pix_o,
    input logic        valid_o,
    input logic [1:0]  mode_q,
    input logic        row_phase
);

    AST_VALID_HIGH: assert property (@(posedge clk) disable iff (!rst_n) de_i |=> valid_o); // R3
    AST_VALID_LOW: assert property (@(posedge clk) disable iff (!rst_n) !de_i |=> !valid_o); // R3
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !frame_start_i |=> $stable(mode_q)); // R1
    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == 2'd0 || mode_q == 2'd3) |=> pix_o == $past(pass_pix_i)); // R2
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ((mode_q == 2'd1 || mode_q == 2'd2) && !de_i) |=> pix_o == '0); // R4
    AST_CHK_TWO_COLOURS: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == 2'd1 && de_i) |=> (pix_o == $past(color_a_i) || pix_o == $past(color_b_i))); // R5
    AST_CHK_LINE_HEAD: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == 2'd1 && de_i && !valid_o) |=> pix_o == (row_phase_d ? $past(color_b_i) : $past(color_a_i))); // R6
    AST_RAMP_HEAD: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == 2'd2 && de_i && !valid_o) |=> pix_o == '0); // R7

    logic row_phase_d;
    // Row phase seen by the previous pixel, for the line-head check.
    always_ff @(posedge clk) begin
        row_phase_d <= row_phase;
    end

endmodule

bind testpat_gen testpat_gen_checks u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .de_i          (de_i),
    .frame_start_i (frame_start_i),
    .color_a_i     (color_a_i),
    .color_b_i     (color_b_i),
    .pass_pix_i    (pass_pix_i),
    .pix_o         (pix_o),
    .valid_o       (valid_o),
    .mode_q        (mode_q),
    .row_phase     (row_phase)
);

// File: tb/testpat_gen_test.sv
// Bench for testpat_gen: fixed-seed random frames plus directed corners,
// compared each cycle against a behavioural model held in the bench.
module testpat_gen_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int unsigned SEED = 32'h5EED_0A17;
    localparam int unsigned WATCHDOG_CYCLES = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        de_i = 1'b0;
    logic        line_start_i = 1'b0;
    logic        frame_start_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [23:0] color_a_i = '0;
    logic [23:0] color_b_i = '0;
    logic [7:0]  run_a_i = 8'd1;
    logic [7:0]  run_b_i = 8'd1;
    logic [7:0]  alt_lines_i = 8'd1;
    logic [7:0]  ramp_step_i = '0;
    logic [23:0] pass_pix_i = '0;
    logic [23:0] pix_o;
    logic        valid_o;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    // Model state and pending expectation.
    logic [1:0]  bm_mode = 2'd0;
    int          bm_lines = 0;
    int          bm_x = 0;
    bit          bm_prev_de = 1'b0;
    bit          exp_on = 1'b0;
    bit          exp_valid;
    logic [23:0] exp_pix;
    string       exp_tag;
    string       tag_force = "";

    testpat_gen uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .de_i          (de_i),
        .line_start_i  (line_start_i),
        .frame_start_i (frame_start_i),
        .mode_i        (mode_i),
        .color_a_i     (color_a_i),
        .color_b_i     (color_b_i),
        .run_a_i       (run_a_i),
        .run_b_i       (run_b_i),
        .alt_lines_i   (alt_lines_i),
        .ramp_step_i   (ramp_step_i),
        .pass_pix_i    (pass_pix_i),
        .pix_o         (pix_o),
        .valid_o       (valid_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int eff(input logic [7:0] v);
        return (v == 8'd0) ? 256 : int'(v);
    endfunction

    // Colour B selected at pixel x for a given row phase (R5).
    function automatic bit chk_is_b(input int x, input bit phase,
                                    input logic [7:0] ra, input logic [7:0] rb);
        bit s = phase;
        int rem = x;
        while (rem >= (s ? eff(rb) : eff(ra))) begin
            rem -= (s ? eff(rb) : eff(ra));
            s = ~s;
        end
        return s;
    endfunction

    function automatic logic [23:0] model_pix(input bit de, input int x);
        bit phase;
        logic [7:0] lvl;
        if (bm_mode == 2'd0 || bm_mode == 2'd3) return pass_pix_i;
        if (!de) return '0;
        if (bm_mode == 2'd1) begin
            phase = ((bm_lines / eff(alt_lines_i)) % 2) == 1;
            return chk_is_b(x, phase, run_a_i, run_b_i) ? color_b_i : color_a_i;
        end
        lvl = 8'((x * int'(ramp_step_i)) % 256);
        return {lvl, lvl, lvl};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: check the previous cycle's result, apply new inputs.
    task automatic step(input bit de, input bit ls, input bit fs);
        int x;
        @(negedge clk);
        if (exp_on) begin
            check(valid_o == exp_valid, "R3", {23'd0, valid_o}, {23'd0, exp_valid});
            check(pix_o == exp_pix, exp_tag, pix_o, exp_pix);
        end
        de_i = de;
        line_start_i = ls;
        frame_start_i = fs;
        pass_pix_i = 24'($urandom);
        x = (de && !bm_prev_de) ? 0 : bm_x;
        exp_valid = de;
        exp_pix = model_pix(de, x);
        if (tag_force != "") exp_tag = tag_force;
        else if (mode_i != bm_mode) exp_tag = "R1";
        else if (bm_mode == 2'd1) exp_tag = de ? "R5" : "R4";
        else if (bm_mode == 2'd2) exp_tag = de ? "R7" : "R4";
        else exp_tag = "R2";
        exp_on = 1'b1;
        bm_x = x + 1;
        bm_prev_de = de;
        if (fs) begin
            bm_mode = mode_i;
            bm_lines = 0;
        end else if (ls) begin
            bm_lines++;
        end
    endtask

    task automatic frame(input int width, input int nlines, input bit with_fs);
        step(1'b0, 1'b0, with_fs);
        step(1'b0, 1'b0, 1'b0);
        for (int l = 0; l < nlines; l++) begin
            step(1'b0, 1'b1, 1'b0);
            step(1'b0, 1'b0, 1'b0);
            for (int w = 0; w < width; w++) step(1'b1, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b0);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(SEED));
        // R9: reset state with active stimulus present.
        mode_i = 2'd1;
        de_i = 1'b1;
        frame_start_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pix_o == '0, "R9", pix_o, '0);
        check(valid_o == 1'b0, "R9", {23'd0, valid_o}, '0);
        de_i = 1'b0;
        frame_start_i = 1'b0;
        rst_n = 1'b1;

        // R9/R1: selector is off after reset until a frame start is seen.
        color_a_i = 24'h112233;
        color_b_i = 24'h445566;
        tag_force = "R9";
        frame(6, 2, 1'b0);
        tag_force = "";

        // R8: directed colours with the default-style settings.
        mode_i = 2'd1;
        color_a_i = 24'hFECC00;
        color_b_i = 24'h006AA7;
        run_a_i = 8'd60;
        run_b_i = 8'd60;
        alt_lines_i = 8'd60;
        tag_force = "R8";
        frame(200, 125, 1'b1);
        tag_force = "";

        // R6: single-line alternation and frame start resetting the phase.
        run_a_i = 8'd3;
        run_b_i = 8'd2;
        alt_lines_i = 8'd1;
        frame(11, 4, 1'b1);
        frame(11, 3, 1'b1);

        // R5: run length zero means 256 pixels.
        run_a_i = 8'd0;
        run_b_i = 8'd5;
        alt_lines_i = 8'd2;
        frame(270, 3, 1'b1);

        // R7: ramp wrap with a large step, then standard step.
        mode_i = 2'd2;
        ramp_step_i = 8'hFF;
        frame(20, 2, 1'b1);
        ramp_step_i = 8'd16;
        frame(40, 2, 1'b1);

        // R1: selector changed mid-frame must not take effect.
        mode_i = 2'd1;
        frame(10, 2, 1'b0);

        // R2: reserved selector behaves as off.
        mode_i = 2'd3;
        frame(8, 2, 1'b1);

        // Random frames.
        for (int f = 0; f < 60; f++) begin
            mode_i = 2'($urandom_range(0, 3));
            color_a_i = 24'($urandom);
            color_b_i = 24'($urandom);
            run_a_i = 8'($urandom_range(1, 9));
            run_b_i = 8'($urandom_range(1, 9));
            alt_lines_i = 8'($urandom_range(0, 7) == 0 ? 0 : $urandom_range(1, 4));
            ramp_step_i = 8'($urandom);
            frame(int'($urandom_range(3, 40)), int'($urandom_range(3, 8)), 1'b1);
            if ($urandom_range(0, 3) == 0) begin
                mode_i = 2'($urandom_range(0, 3));
                frame(12, 2, 1'b0);
            end
        end

        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule